// File: doc/BRIEF.md
# Flash Array Model with Fault Injection

This block models a small single-bit-per-address flash array laid out as rows (word-lines) by columns (bit-lines), for use as the device under test of a memory self-test controller. It obeys flash rules. An erase clears the whole array to 1. A program can only pull one addressed cell from 1 to 0. A read returns one cell. There is no way to write a 1 to a single cell. Each operation is accepted through a request strobe and then holds `busy` high for a parameterised number of cycles. Erase takes longest, program takes less, and read takes least.

One functional fault can be injected at a time into a chosen victim cell. The available faults are:

- program or erase disturb triggered along the victim's row;
- program or erase disturb triggered along the victim's column;
- read disturb;
- over-erase, including leakage onto the victim's column;
- stuck-at faults;
- failed transitions.

The fault selection is captured when an erase is accepted. It stays in force until the next erase, so a test controller arms a fault and then runs its march sequence.

Top module: `flash_fault_array`

## Requirements
- R1: While `rst` is high and in the first cycle after it falls, `busy`, `rd_valid` and `rd_data` are 0.
- R2: A request is accepted when `req_valid` is high, `busy` is low and `req_op` is not 0. The op codes are 1 = erase, 2 = program and 3 = read. `busy` rises in the next cycle and stays high for exactly ROWS*COLS+ERASE_XTRA cycles for an erase, PROG_CYC cycles for a program, and READ_CYC cycles for a read. Requests with op 0, or requests made while `busy` is high, have no effect.
- R3: The cell at row r, column c has address r*COLS+c, with the row in the upper address bits. An erase sets every cell to 1. A program sets only the addressed cell to 0.
- R4: `rd_valid` is high for exactly one cycle: the first cycle in which `busy` is low after a read. `rd_data` then holds the cell value until the next read completes.
- R5: Fault code 1: a program of another cell in the victim's row sets the victim to 0. Fault code 2: the same trigger sets the victim to 1. Programs elsewhere do not disturb the victim.
- R6: Fault code 3: a program of another cell in the victim's column sets the victim to 0. Fault code 4: the same trigger sets the victim to 1. Programs elsewhere do not disturb the victim.
- R7: Fault code 5: a read of the victim while it holds 0 returns 0 and leaves the victim at 1.
- R8: Fault code 6: programming the victim leaves it at 1. A read of any other cell in the victim's column returns 1.
- R9: Fault codes 7 and 8: the victim reads as 0 or 1 respectively after any erase, and after any program.
- R10: Fault code 9 (a failed rise): the victim stays 0 through erase. Fault code 10 (a failed fall): the victim stays 1 when it is programmed.
- R11: `cfg_en`, `cfg_kind`, `cfg_row` and `cfg_col` are sampled only when an erase is accepted. Changes between erases have no effect. If `cfg_en` is low, or the code is 0 or greater than 10, the array behaves fault-free.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Operation request strobe |
| req_op | input | 2 | 0 none, 1 erase, 2 program, 3 read |
| req_addr | input | clog2(ROWS)+clog2(COLS) | Cell address {row, column} |
| cfg_en | input | 1 | Fault injection enable |
| cfg_kind | input | 4 | Fault code |
| cfg_row | input | clog2(ROWS) | Victim row |
| cfg_col | input | clog2(COLS) | Victim column |
| busy | output | 1 | Operation in progress |
| rd_valid | output | 1 | One-cycle read completion pulse |
| rd_data | output | 1 | Last read value |

## Verification
The bench sweeps every cell after an erase and after a computed program pattern, so an address mapping that swaps row and column bits, or an erase that misses cells, shows up as wrong bits. Each disturb fault is driven once by an aggressor on the victim's line and once by one on the crossing line. A model that compares the wrong coordinate would disturb on the wrong trigger or not at all. Read disturb is checked on two consecutive reads, which catches a victim that flips before the first value is returned. The capture test changes the fault inputs between erases, so a design that decodes them live would follow the new setting.

// File: rtl/flt_pkg.sv
package flt_pkg;

  typedef enum logic [1:0] {
    OP_NOP   = 2'd0,
    OP_ERASE = 2'd1,
    OP_PROG  = 2'd2,
    OP_READ  = 2'd3
  } op_e;

  typedef enum logic [3:0] {
    FK_NONE       = 4'd0,
    FK_ROW_PDIST  = 4'd1,
    FK_ROW_EDIST  = 4'd2,
    FK_COL_PDIST  = 4'd3,
    FK_COL_EDIST  = 4'd4,
    FK_READ_DIST  = 4'd5,
    FK_OVER_ERASE = 4'd6,
    FK_STUCK0     = 4'd7,
    FK_STUCK1     = 4'd8,
    FK_NO_RISE    = 4'd9,
    FK_NO_FALL    = 4'd10
  } fault_e;

  localparam int unsigned FK_LAST = 10;

endpackage

// File: rtl/flash_cell_store.sv
module flash_cell_store #(
  parameter int unsigned AW = 8
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic          wdata,
  input  logic [AW-1:0] raddr,
  output logic          rdata
);
  localparam int unsigned DEPTH = 1 << AW;

  logic cells [DEPTH];

  // one write port, one registered read port: maps onto block RAM
  always_ff @(posedge clk) begin
    if (we) cells[waddr] <= wdata;
    rdata <= cells[raddr];
  end

endmodule

// File: rtl/flash_op_seq.sv
module flash_op_seq
  import flt_pkg::*;
#(
  parameter int unsigned AW         = 8,
  parameter int unsigned ERASE_LEN  = 296,
  parameter int unsigned PROG_LEN   = 6,
  parameter int unsigned READ_LEN   = 3
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          req_valid,
  input  op_e           req_op,
  input  logic [AW-1:0] req_addr,
  output logic          busy,
  output logic          rd_valid,
  output logic [AW-1:0] op_addr,
  output logic          erase_go,
  output logic          prog_done,
  output logic          read_done,
  output logic          sweep_we,
  output logic [AW-1:0] sweep_addr
);
  localparam int unsigned LW = $clog2(ERASE_LEN + 1);

  op_e           cur_op;
  logic [LW-1:0] cnt;
  logic [LW-1:0] len_sel;
  logic          accept;
  logic          done;

  assign accept    = req_valid && !busy && (req_op != OP_NOP);
  assign erase_go  = accept && (req_op == OP_ERASE);
  assign done      = busy && (cnt == '0);
  assign prog_done = done && (cur_op == OP_PROG);
  assign read_done = done && (cur_op == OP_READ);

  always_comb begin
    case (req_op)
      OP_ERASE: len_sel = LW'(ERASE_LEN - 1);
      OP_PROG:  len_sel = LW'(PROG_LEN - 1);
      default:  len_sel = LW'(READ_LEN - 1);
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      busy       <= 1'b0;
      rd_valid   <= 1'b0;
      cnt        <= '0;
      cur_op     <= OP_NOP;
      op_addr    <= '0;
      sweep_we   <= 1'b0;
      sweep_addr <= '0;
    end else begin
      rd_valid <= 1'b0;
      if (accept) begin
        busy       <= 1'b1;
        cur_op     <= req_op;
        op_addr    <= req_addr;
        cnt        <= len_sel;
        sweep_we   <= (req_op == OP_ERASE);
        sweep_addr <= '0;
      end else begin
        if (busy) begin
          if (cnt == '0) begin
            busy     <= 1'b0;
            rd_valid <= (cur_op == OP_READ);
          end else begin
            cnt <= cnt - 1'b1;
          end
        end
        if (sweep_we) begin
          if (&sweep_addr) sweep_we <= 1'b0;
          sweep_addr <= sweep_addr + 1'b1;
        end
      end
    end
  end

  AST_BUSY_FROM_REQ: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> ($past(req_valid) && ($past(req_op) != OP_NOP))); // R2

  AST_RDV_AFTER_BUSY: assert property (@(posedge clk) disable iff (rst)
    rd_valid |-> (!busy && $past(busy))); // R4

  AST_RDV_SINGLE: assert property (@(posedge clk) disable iff (rst)
    rd_valid |=> !rd_valid); // R4

  AST_SWEEP_IN_BUSY: assert property (@(posedge clk) disable iff (rst)
    sweep_we |-> busy); // R3

endmodule

// File: rtl/flash_fault_unit.sv
module flash_fault_unit
  import flt_pkg::*;
#(
  parameter int unsigned RW = 4,
  parameter int unsigned CW = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          arm,
  input  logic          cfg_en,
  input  fault_e        cfg_kind,
  input  logic [RW-1:0] cfg_row,
  input  logic [CW-1:0] cfg_col,
  input  logic          prog_done,
  input  logic          read_done,
  input  logic [RW-1:0] op_row,
  input  logic [CW-1:0] op_col,
  input  logic          mem_q,
  output logic          rd_data
);
  fault_e        kind_q;
  fault_e        kind_in;
  logic [RW-1:0] vrow;
  logic [CW-1:0] vcol;
  logic          vic_bit;
  logic          vic_hit, same_row, same_col, active;
  logic          rd_val;
  logic          prog_locked;

  assign kind_in     = cfg_en ? cfg_kind : FK_NONE;
  assign vic_hit     = (op_row == vrow) && (op_col == vcol);
  assign same_row    = (op_row == vrow) && !vic_hit;
  assign same_col    = (op_col == vcol) && !vic_hit;
  assign active      = (kind_q != FK_NONE);
  assign prog_locked = (kind_q == FK_STUCK0) || (kind_q == FK_STUCK1) ||
                       (kind_q == FK_NO_RISE) || (kind_q == FK_NO_FALL) ||
                       (kind_q == FK_OVER_ERASE);

  always_comb begin
    if (active && vic_hit)                             rd_val = vic_bit;
    else if ((kind_q == FK_OVER_ERASE) && same_col)    rd_val = 1'b1;
    else                                               rd_val = mem_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      kind_q  <= FK_NONE;
      vrow    <= '0;
      vcol    <= '0;
      vic_bit <= 1'b1;
      rd_data <= 1'b0;
    end else begin
      if (arm) begin
        kind_q  <= kind_in;
        vrow    <= cfg_row;
        vcol    <= cfg_col;
        vic_bit <= !((kind_in == FK_STUCK0) || (kind_in == FK_NO_RISE));
      end else if (prog_done) begin
        if (vic_hit) begin
          if (!prog_locked) vic_bit <= 1'b0;
        end else begin
          case (kind_q)
            FK_ROW_PDIST: if (same_row) vic_bit <= 1'b0;
            FK_ROW_EDIST: if (same_row) vic_bit <= 1'b1;
            FK_COL_PDIST: if (same_col) vic_bit <= 1'b0;
            FK_COL_EDIST: if (same_col) vic_bit <= 1'b1;
            default: ;
          endcase
        end
      end else if (read_done) begin
        rd_data <= rd_val;
        if ((kind_q == FK_READ_DIST) && vic_hit && !vic_bit) vic_bit <= 1'b1;
      end
    end
  end

  AST_ROWP_NO_RAISE: assert property (@(posedge clk) disable iff (rst)
    (prog_done && (kind_q == FK_ROW_PDIST)) |=> !$rose(vic_bit)); // R5

  AST_COLE_NO_DROP: assert property (@(posedge clk) disable iff (rst)
    (prog_done && (kind_q == FK_COL_EDIST) && !vic_hit) |=> !$fell(vic_bit)); // R6

  AST_RDIST_FLIP: assert property (@(posedge clk) disable iff (rst)
    (read_done && (kind_q == FK_READ_DIST) && vic_hit && !vic_bit) |=> (!rd_data && vic_bit)); // R7

  AST_OE_LEAK: assert property (@(posedge clk) disable iff (rst)
    (read_done && (kind_q == FK_OVER_ERASE) && same_col) |=> rd_data); // R8

  AST_STUCK_LOW: assert property (@(posedge clk) disable iff (rst)
    (read_done && vic_hit && ((kind_q == FK_STUCK0) || (kind_q == FK_NO_RISE))) |=> !rd_data); // R9

endmodule

// File: rtl/flash_fault_array.sv
module flash_fault_array
  import flt_pkg::*;
#(
  parameter int unsigned ROWS       = 16,
  parameter int unsigned COLS       = 16,
  parameter int unsigned ERASE_XTRA = 40,
  parameter int unsigned PROG_CYC   = 6,
  parameter int unsigned READ_CYC   = 3
) (
  input  logic                                 clk,
  input  logic                                 rst,
  input  logic                                 req_valid,
  input  logic [1:0]                           req_op,
  input  logic [$clog2(ROWS)+$clog2(COLS)-1:0] req_addr,
  input  logic                                 cfg_en,
  input  logic [3:0]                           cfg_kind,
  input  logic [$clog2(ROWS)-1:0]              cfg_row,
  input  logic [$clog2(COLS)-1:0]              cfg_col,
  output logic                                 busy,
  output logic                                 rd_valid,
  output logic                                 rd_data
);
  localparam int unsigned RW        = $clog2(ROWS);
  localparam int unsigned CW        = $clog2(COLS);
  localparam int unsigned AW        = RW + CW;
  localparam int unsigned CELLS     = ROWS * COLS;
  localparam int unsigned ERASE_LEN = CELLS + ((ERASE_XTRA < 1) ? 1 : ERASE_XTRA);
  localparam int unsigned PROG_LEN  = (PROG_CYC < 1) ? 1 : PROG_CYC;
  localparam int unsigned READ_LEN  = (READ_CYC < 2) ? 2 : READ_CYC; // registered array read needs 2

  logic [AW-1:0] op_addr, sweep_addr, waddr;
  logic          erase_go, prog_done, read_done, sweep_we;
  logic          mem_we, mem_q;
  fault_e        kind_in;

  assign kind_in = (cfg_kind <= 4'(FK_LAST)) ? fault_e'(cfg_kind) : FK_NONE;

  flash_op_seq #(
    .AW(AW), .ERASE_LEN(ERASE_LEN), .PROG_LEN(PROG_LEN), .READ_LEN(READ_LEN)
  ) u_seq (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_op(op_e'(req_op)),
    .req_addr(req_addr), .busy(busy), .rd_valid(rd_valid), .op_addr(op_addr),
    .erase_go(erase_go), .prog_done(prog_done), .read_done(read_done),
    .sweep_we(sweep_we), .sweep_addr(sweep_addr)
  );

  assign mem_we = sweep_we || prog_done;
  assign waddr  = sweep_we ? sweep_addr : op_addr;

  flash_cell_store #(.AW(AW)) u_store (
    .clk(clk), .we(mem_we), .waddr(waddr), .wdata(sweep_we),
    .raddr(op_addr), .rdata(mem_q)
  );

  flash_fault_unit #(.RW(RW), .CW(CW)) u_fault (
    .clk(clk), .rst(rst), .arm(erase_go), .cfg_en(cfg_en), .cfg_kind(kind_in),
    .cfg_row(cfg_row), .cfg_col(cfg_col), .prog_done(prog_done),
    .read_done(read_done), .op_row(op_addr[AW-1:CW]), .op_col(op_addr[CW-1:0]),
    .mem_q(mem_q), .rd_data(rd_data)
  );

  AST_IDLE_AFTER_RESET: assert property (@(posedge clk)
    $past(rst) |-> (!busy && !rd_valid && !rd_data)); // R1

endmodule

// File: tb/test_flash_fault_array.sv
module test_flash_fault_array;
  localparam int ROWS = 16, COLS = 16, XTRA = 40, PCYC = 6, RCYC = 3;

  logic clk = 0, rst = 1;
  logic req_valid = 0;
  logic [1:0] req_op = 0;
  logic [7:0] req_addr = 0;
  logic cfg_en = 0;
  logic [3:0] cfg_kind = 0;
  logic [3:0] cfg_row = 0, cfg_col = 0;
  logic busy, rd_valid, rd_data;
  int checks = 0, fails = 0, cycles = 0;

  always #2 clk = ~clk;

  flash_fault_array #(.ROWS(ROWS), .COLS(COLS), .ERASE_XTRA(XTRA),
                      .PROG_CYC(PCYC), .READ_CYC(RCYC)) i_flash_fault_array (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_op(req_op),
    .req_addr(req_addr), .cfg_en(cfg_en), .cfg_kind(cfg_kind),
    .cfg_row(cfg_row), .cfg_col(cfg_col), .busy(busy),
    .rd_valid(rd_valid), .rd_data(rd_data)
  );

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      fails++;
      $display("FAIL watchdog: run hung, actual %0d cycles expected < 150000", cycles);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic logic [7:0] ad(input int r, input int c);
    return 8'(r * COLS + c);
  endfunction

  // issue one op; returns number of cycles busy was high and rd_valid seen after
  task automatic op(input logic [1:0] code, input logic [7:0] a,
                    output int lat, output logic rv);
    @(negedge clk);
    req_valid = 1; req_op = code; req_addr = a;
    @(negedge clk);
    req_valid = 0; req_op = 0;
    lat = 0;
    while (busy) begin lat++; @(negedge clk); end
    rv = rd_valid;
  endtask

  task automatic erase();
    int l; logic v;
    op(2'd1, 8'd0, l, v);
  endtask

  task automatic prog(input int r, input int c);
    int l; logic v;
    op(2'd2, ad(r, c), l, v);
  endtask

  task automatic rd(input int r, input int c, output logic d);
    int l; logic v;
    op(2'd3, ad(r, c), l, v);
    d = rd_data;
  endtask

  task automatic arm(input int en, input int k, input int r, input int c);
    cfg_en = en[0]; cfg_kind = 4'(k); cfg_row = 4'(r); cfg_col = 4'(c);
    erase();
  endtask

  initial begin
    int l; logic v, d;
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    // R1 reset state
    chk("R1 busy", busy, 0);
    chk("R1 rd_valid", rd_valid, 0);
    chk("R1 rd_data", rd_data, 0);

    // R2 latencies, R11 disabled fault
    cfg_en = 0; cfg_kind = 4'd7;
    op(2'd1, 8'd0, l, v);
    chk("R2 erase latency", l, ROWS * COLS + XTRA);
    op(2'd2, ad(0, 0), l, v);
    chk("R2 program latency", l, PCYC);
    op(2'd3, ad(0, 0), l, v);
    chk("R2 read latency", l, RCYC);
    chk("R4 rd_valid pulse", v, 1);
    chk("R3 programmed cell", rd_data, 0);
    @(negedge clk);
    chk("R4 rd_valid one cycle", rd_valid, 0);
    chk("R4 rd_data held", rd_data, 0);
    op(2'd0, 8'd5, l, v);
    chk("R2 nop ignored", l, 0);

    // R3 full sweeps: erase then pattern
    erase();
    for (int r = 0; r < ROWS; r++)
      for (int c = 0; c < COLS; c++) begin
        rd(r, c, d);
        chk("R3 erased cell", d, 1);
      end
    for (int r = 0; r < ROWS; r++)
      for (int c = 0; c < COLS; c++)
        if ((r * 3 + c) % 5 == 0) prog(r, c);
    prog(0, 0); // repeat program of a 0 cell
    for (int r = 0; r < ROWS; r++)
      for (int c = 0; c < COLS; c++) begin
        rd(r, c, d);
        chk("R3 pattern cell", d, ((r * 3 + c) % 5 == 0) ? 0 : 1);
      end

    // R2 request while busy ignored
    @(negedge clk);
    req_valid = 1; req_op = 2'd1;
    @(negedge clk);
    req_op = 2'd2; req_addr = ad(4, 4);
    @(negedge clk);
    req_valid = 0; req_op = 0;
    while (busy) @(negedge clk);
    rd(4, 4, d);
    chk("R2 program during busy ignored", d, 1);

    // R5 row disturb
    arm(1, 1, 5, 7);
    prog(9, 7);
    rd(5, 7, d); chk("R5 code1 column aggressor no effect", d, 1);
    prog(5, 2);
    rd(5, 7, d); chk("R5 code1 row aggressor", d, 0);
    rd(5, 2, d); chk("R5 aggressor programmed", d, 0);
    arm(1, 2, 5, 7);
    prog(5, 7);
    rd(5, 7, d); chk("R5 code2 victim programmed", d, 0);
    prog(5, 9);
    rd(5, 7, d); chk("R5 code2 row aggressor", d, 1);

    // R6 column disturb
    arm(1, 3, 5, 7);
    prog(5, 1);
    rd(5, 7, d); chk("R6 code3 row aggressor no effect", d, 1);
    prog(9, 7);
    rd(5, 7, d); chk("R6 code3 column aggressor", d, 0);
    arm(1, 4, 5, 7);
    prog(5, 7);
    prog(2, 7);
    rd(5, 7, d); chk("R6 code4 column aggressor", d, 1);

    // R7 read disturb
    arm(1, 5, 5, 7);
    rd(5, 7, d); chk("R7 erased victim read", d, 1);
    prog(5, 7);
    rd(5, 7, d); chk("R7 first read returns 0", d, 0);
    rd(5, 7, d); chk("R7 second read returns 1", d, 1);

    // R8 over-erase
    arm(1, 6, 5, 7);
    prog(5, 7);
    rd(5, 7, d); chk("R8 victim not programmable", d, 1);
    prog(3, 7);
    rd(3, 7, d); chk("R8 column leak", d, 1);
    prog(3, 8);
    rd(3, 8, d); chk("R8 other column normal", d, 0);

    // R9 stuck-at
    arm(1, 7, 2, 3);
    rd(2, 3, d); chk("R9 stuck0 after erase", d, 0);
    arm(1, 8, 2, 3);
    prog(2, 3);
    rd(2, 3, d); chk("R9 stuck1 after program", d, 1);

    // R10 transition faults
    arm(1, 9, 2, 3);
    rd(2, 3, d); chk("R10 no rise on erase", d, 0);
    arm(1, 10, 2, 3);
    prog(2, 3);
    rd(2, 3, d); chk("R10 no fall on program", d, 1);

    // R11 capture at erase only
    arm(1, 1, 5, 7);
    cfg_kind = 4'd3; cfg_row = 0; cfg_col = 0;
    prog(9, 7);
    rd(5, 7, d); chk("R11 live config ignored", d, 1);
    prog(0, 5);
    rd(0, 0, d); chk("R11 new victim unaffected", d, 1);
    prog(5, 0);
    rd(5, 7, d); chk("R11 captured fault active", d, 0);
    arm(0, 1, 5, 7);
    prog(5, 2);
    rd(5, 7, d); chk("R11 disabled no fault", d, 1);
    arm(1, 12, 5, 7);
    prog(5, 2);
    rd(5, 7, d); chk("R11 unknown code fault-free", d, 1);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule